// File: doc/BRIEF.md
# Privilege-Aware Flags Merge Unit

This unit produces the flags register value that results from a return from an interrupt. It takes the current 32-bit flags word and the flags image taken off the stack. A write mask decides, bit by bit, which of the two sources is kept. The mask depends on two things: the privilege level that was in force before the return, and the I/O privilege level held in the current flags. A third input can cut the mask down to its low half for a return to a 16-bit code segment.

When the load strobe is high, the merged value is captured in a register. The register then holds until the next strobe. The reserved bits are forced to fixed values, whatever the sources carry. The virtual-mode bit is always taken from the current flags.

Top module: `flags_merge_unit`

## Requirements
- R1: After reset, `flags_q` reads 0x00000002.
- R2: While `load_i` is low, `flags_q` keeps its value, whatever the other inputs do.
- R3: On a load, these bits of `flags_q` come from `pop_flags_i`: carry (bit 0), parity (2), adjust (4), zero (6), sign (7), trap (8), direction (10), overflow (11), nested-task (14) and resume (16).
- R4: With `HAS_ID_AC` = 1 (the default), alignment-check (bit 18) and identification (bit 21) are loaded from `pop_flags_i`. With `HAS_ID_AC` = 0 they keep their current values.
- R5: Interrupt enable (bit 9) is loaded from `pop_flags_i` only when `prev_cpl_i` <= the I/O privilege level in `cur_flags_i[13:12]`. Otherwise it takes `cur_flags_i[9]`.
- R6: The I/O privilege field (bits 13:12), virtual interrupt flag (bit 19) and virtual interrupt pending (bit 20) are loaded from `pop_flags_i` only when `prev_cpl_i` is 0. Otherwise they take their values from `cur_flags_i`.
- R7: The virtual-mode bit (bit 17) always takes `cur_flags_i[17]` on a load.
- R8: When `trunc16_i` is high on a load, `flags_q[31:16]` equals `cur_flags_i[31:16]`.
- R9: `flags_q[1]` always reads 1, and bits 3, 5 and 15 always read 0.
- R10: Bits 31:22 always take their values from `cur_flags_i` on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| load_i | input | 1 | Capture the merged flags value |
| cur_flags_i | input | 32 | Current flags register value |
| pop_flags_i | input | 32 | Flags image taken off the stack |
| prev_cpl_i | input | 2 | Privilege level in force before the return |
| trunc16_i | input | 1 | Restrict the write mask to bits 15:0 |
| flags_q | output | 32 | Registered merged flags |

## Verification
The merge is driven with three kinds of input. An all-ones popped image over an all-zero current word shows exactly which bits the mask opens. An all-zero popped image over an all-ones current word shows the same mask from the other side, and it also exposes the upper-half cut. Mixed words test the virtual-mode bit and the reserved bits.

The privilege level before the return is swept over 0, 1 and 3, with I/O privilege levels that lie below, at and above it. This separates the comparison that governs interrupt enable from the level-zero-only fields. Holding the strobe low while the inputs change confirms that the register holds.

// File: rtl/flagmerge_pkg.sv
package flagmerge_pkg;
  localparam int FLAG_W = 32;

  // Architectural bit positions (the merge depends on them).
  localparam int B_CF   = 0;
  localparam int B_RSV1 = 1;
  localparam int B_PF   = 2;
  localparam int B_RSV3 = 3;
  localparam int B_AF   = 4;
  localparam int B_RSV5 = 5;
  localparam int B_ZF   = 6;
  localparam int B_SF   = 7;
  localparam int B_TF   = 8;
  localparam int B_IF   = 9;
  localparam int B_DF   = 10;
  localparam int B_OF   = 11;
  localparam int B_IOPL = 12;
  localparam int B_NT   = 14;
  localparam int B_RSV15 = 15;
  localparam int B_RF   = 16;
  localparam int B_VM   = 17;
  localparam int B_AC   = 18;
  localparam int B_VIF  = 19;
  localparam int B_VIP  = 20;
  localparam int B_ID   = 21;

  localparam int HALF_W = FLAG_W / 2;

  typedef logic [FLAG_W-1:0] flags_t;

  localparam flags_t BASE_MASK =
      (flags_t'(1) << B_CF) | (flags_t'(1) << B_PF) | (flags_t'(1) << B_AF) |
      (flags_t'(1) << B_ZF) | (flags_t'(1) << B_SF) | (flags_t'(1) << B_TF) |
      (flags_t'(1) << B_DF) | (flags_t'(1) << B_OF) | (flags_t'(1) << B_NT) |
      (flags_t'(1) << B_RF);

  localparam flags_t IDAC_MASK = (flags_t'(1) << B_AC) | (flags_t'(1) << B_ID);

  localparam flags_t RING0_MASK =
      (flags_t'(3) << B_IOPL) | (flags_t'(1) << B_VIF) | (flags_t'(1) << B_VIP);

  localparam flags_t FORCE_ONE  = flags_t'(1) << B_RSV1;
  localparam flags_t FORCE_ZERO =
      (flags_t'(1) << B_RSV3) | (flags_t'(1) << B_RSV5) | (flags_t'(1) << B_RSV15);

  localparam flags_t RESET_FLAGS = FORCE_ONE;
endpackage

// File: rtl/flagmerge_rst_sync.sv
module flagmerge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/flagmerge_mask_gen.sv
module flagmerge_mask_gen
  import flagmerge_pkg::*;
#(
  parameter bit HAS_ID_AC = 1'b1
) (
  input  logic [1:0] prev_cpl_i,
  input  logic [1:0] cur_iopl_i,
  input  logic       trunc16_i,
  output flags_t     mask_o
);
  flags_t feature_mask;
  flags_t priv_mask;
  flags_t full_mask;

  generate
    if (HAS_ID_AC) begin : g_idac
      assign feature_mask = IDAC_MASK;
    end else begin : g_no_idac
      assign feature_mask = '0;
    end
  endgenerate

  always_comb begin
    priv_mask = '0;
    if (prev_cpl_i <= cur_iopl_i) priv_mask[B_IF] = 1'b1;
    if (prev_cpl_i == 2'd0)       priv_mask = priv_mask | RING0_MASK;
  end

  assign full_mask = BASE_MASK | feature_mask | priv_mask;

  always_comb begin
    mask_o = full_mask;
    if (trunc16_i) mask_o[FLAG_W-1:HALF_W] = '0;
  end
endmodule

// File: rtl/flagmerge_blend.sv
module flagmerge_blend
  import flagmerge_pkg::*;
(
  input  flags_t cur_i,
  input  flags_t pop_i,
  input  flags_t mask_i,
  output flags_t merged_o
);
  flags_t raw;

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
      assign raw[gi] = mask_i[gi] ? pop_i[gi] : cur_i[gi];
    end
  endgenerate

  assign merged_o = (raw | FORCE_ONE) & ~FORCE_ZERO;
endmodule

// File: rtl/flagmerge_reg.sv
module flagmerge_reg
  import flagmerge_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  flags_t q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_FLAGS;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/flags_merge_unit.sv
module flags_merge_unit
  import flagmerge_pkg::*;
#(
  parameter bit HAS_ID_AC = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] cur_flags_i,
  input  logic [31:0] pop_flags_i,
  input  logic [1:0]  prev_cpl_i,
  input  logic        trunc16_i,
  output logic [31:0] flags_q
);
  logic   rst_n_sync;
  flags_t mask;
  flags_t merged;

  flagmerge_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  flagmerge_mask_gen #(.HAS_ID_AC(HAS_ID_AC)) u_mask (
    .prev_cpl_i (prev_cpl_i),
    .cur_iopl_i (cur_flags_i[B_IOPL+1:B_IOPL]),
    .trunc16_i  (trunc16_i),
    .mask_o     (mask)
  );

  flagmerge_blend u_blend (
    .cur_i    (cur_flags_i),
    .pop_i    (pop_flags_i),
    .mask_i   (mask),
    .merged_o (merged)
  );

  flagmerge_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en_i  (load_i),
    .d_i   (merged),
    .q_o   (flags_q)
  );
endmodule

// File: rtl/flags_merge_unit_chk.sv
module flags_merge_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_i,
  input logic [31:0] cur_flags_i,
  input logic [1:0]  prev_cpl_i,
  input logic        trunc16_i,
  input logic [31:0] flags_q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !$past(load_i)) |-> (flags_q == $past(flags_q)));

  assert_if_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(load_i) && ($past(prev_cpl_i) > $past(cur_flags_i[13:12])))
      |-> (flags_q[9] == $past(cur_flags_i[9])));

  assert_ring0_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(load_i) && ($past(prev_cpl_i) != 2'd0))
      |-> (flags_q[13:12] == $past(cur_flags_i[13:12]) &&
           flags_q[20:19] == $past(cur_flags_i[20:19])));

  assert_vm_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(load_i)) |-> (flags_q[17] == $past(cur_flags_i[17])));

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(load_i) && $past(trunc16_i))
      |-> (flags_q[31:16] == $past(cur_flags_i[31:16])));

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15]);

  assert_reserved_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && $past(load_i)) |-> (flags_q[31:22] == $past(cur_flags_i[31:22])));
endmodule

bind flags_merge_unit flags_merge_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .load_i      (load_i),
  .cur_flags_i (cur_flags_i),
  .prev_cpl_i  (prev_cpl_i),
  .trunc16_i   (trunc16_i),
  .flags_q     (flags_q)
);

// File: tb/tb_flags_merge_unit.sv
`timescale 1ns/1ps
module tb_flags_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i;
  logic [31:0] cur_flags_i;
  logic [31:0] pop_flags_i;
  logic [1:0]  prev_cpl_i;
  logic        trunc16_i;
  logic [31:0] flags_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  flags_merge_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .cur_flags_i (cur_flags_i),
    .pop_flags_i (pop_flags_i),
    .prev_cpl_i  (prev_cpl_i),
    .trunc16_i   (trunc16_i),
    .flags_q     (flags_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
  task automatic do_load(input logic [31:0] cur, input logic [31:0] pop,
                         input logic [1:0] cpl, input logic trunc);
    @(negedge clk);
    cur_flags_i = cur; pop_flags_i = pop; prev_cpl_i = cpl; trunc16_i = trunc;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset value", flags_q, 32'h0000_0002);
  endtask

  task automatic t_ring0_open;
    do_load(32'h0, 32'hFFFF_FFFF, 2'd0, 1'b0);
    check("R3/R4/R5/R6 ring0 all writable", flags_q, 32'h003D_7FD7);
  endtask

  task automatic t_hold;
    @(negedge clk);
    cur_flags_i = 32'h1234_5678; pop_flags_i = 32'h0; prev_cpl_i = 2'd0;
    repeat (3) @(negedge clk);
    check("R2 hold without load", flags_q, 32'h003D_7FD7);
  endtask

  task automatic t_ring3_low_iopl;
    do_load(32'h0, 32'hFFFF_FFFF, 2'd3, 1'b0);
    check("R5/R6 ring3 iopl0 guarded bits kept", flags_q, 32'h0025_4DD7);
    check("R4 AC and ID loaded", flags_q & 32'h0024_0000, 32'h0024_0000);
  endtask

  task automatic t_if_compare;
    do_load(32'h0000_3200, 32'h0, 2'd3, 1'b0);
    check("R5 cpl equals iopl, IF cleared", flags_q, 32'h0000_3002);
    do_load(32'h0000_2200, 32'h0, 2'd3, 1'b0);
    check("R5 cpl above iopl, IF kept", flags_q, 32'h0000_2202);
  endtask

  task automatic t_ring1;
    do_load(32'h0000_1000, 32'hFFFF_FFFF, 2'd1, 1'b0);
    check("R6 ring1 IOPL kept, R5 IF loaded", flags_q, 32'h0025_5FD7);
  endtask

  task automatic t_vm;
    do_load(32'h0002_0000, 32'h0, 2'd0, 1'b0);
    check("R7 VM kept set", flags_q, 32'h0002_0002);
    do_load(32'h0, 32'h0002_0000, 2'd0, 1'b0);
    check("R7 VM kept clear", flags_q, 32'h0000_0002);
  endtask

  task automatic t_trunc;
    do_load(32'hFFFF_0002, 32'h0, 2'd0, 1'b1);
    check("R8 upper half kept", flags_q, 32'hFFFF_0002);
    do_load(32'hFFFF_0002, 32'h0, 2'd0, 1'b0);
    check("R10 high reserved kept, R3 RF cleared", flags_q, 32'hFFC2_0002);
  endtask

  task automatic t_fixed;
    do_load(32'h0000_8028, 32'h0, 2'd0, 1'b0);
    check("R9 fixed bits from current", flags_q, 32'h0000_0002);
    do_load(32'h0, 32'h0000_8028, 2'd0, 1'b0);
    check("R9 fixed bits from popped", flags_q, 32'h0000_0002);
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; cur_flags_i = '0; pop_flags_i = '0;
    prev_cpl_i = '0; trunc16_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ring0_open();
    t_hold();
    t_ring3_low_iopl();
    t_if_compare();
    t_ring1();
    t_vm();
    t_trunc();
    t_fixed();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule